// File: doc/BRIEF.md
# Exclusive Access Reservation Monitor

This block sits beside the load/store decode stage of a 32-bit processor and keeps a single address reservation. An exclusive word load records the address it reads; a later exclusive store only reaches memory if its address still matches that record. The outcome is reported through the carry flag, where 0 means the store went through and 1 means it was dropped. Ordinary loads and stores pass through unchanged. The only thing that decides exclusivity is the local address compare. No exclusive transaction is issued on the memory bus.

Each request gives the store/load kind and the instruction form. It also gives the two instruction bits that select exclusive and byte-reversed access, the size code and the effective address. Interrupt entry and exception entry each drop the reservation. Every output is registered, so the memory qualifiers and the carry write for a request appear together, one cycle after the request.

Top module: `excl_monitor`

## Requirements
- R1: After reset, all outputs are 0 and no reservation is held, so the first exclusive store fails (flag_val 1, mem_req 0).
- R2: A request is exclusive only when req_reg_form is 1 and req_excl is 1. In immediate form (req_reg_form 0), req_excl has no effect: there is no carry write and the address is not aligned.
- R3: mem_bytes equals 1 shifted left by req_size (1, 2, 4 or 8). mem_rev is req_rev in register form and 0 in immediate form.
- R4: For an exclusive request, mem_addr has its two low bits forced to 0. For any other request, the address passes through unaltered.
- R5: An exclusive load performs the read (mem_req 1, mem_we 0) and writes 0 to carry (flag_we 1, flag_val 0). It records its aligned address as the reservation.
- R6: An exclusive store whose aligned address equals the reservation gives mem_req 1, mem_we 1, flag_we 1 and flag_val 0.
- R7: An exclusive store whose aligned address differs from the reservation gives mem_req 0 and flag_we 1 with flag_val 1.
- R8: After any exclusive store, whether it succeeded or failed, no reservation is held.
- R9: An irq_entry or exc_entry pulse drops the reservation. This takes priority over an exclusive load in the same cycle.
- R10: A non-exclusive store always gives mem_req 1 and mem_we 1, with no carry write. It leaves the reservation untouched.
- R11: All outputs for a request appear on the cycle after it is presented. A cycle without req_valid yields all-zero outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | A load/store request is presented |
| req_store | input | 1 | 1 = store, 0 = load |
| req_reg_form | input | 1 | 1 = register-form encoding, 0 = immediate form |
| req_excl | input | 1 | Exclusive-select instruction bit |
| req_rev | input | 1 | Byte-reversed-select instruction bit |
| req_size | input | 2 | Size code; access is 1 << code bytes |
| req_addr | input | 32 | Effective address |
| irq_entry | input | 1 | Interrupt entry pulse |
| exc_entry | input | 1 | Exception entry pulse |
| mem_req | output | 1 | Perform the memory access |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 32 | Access address, word-aligned for exclusives |
| mem_bytes | output | 4 | Access size in bytes |
| mem_rev | output | 1 | Byte-reversed access |
| flag_we | output | 1 | Write the carry flag |
| flag_val | output | 1 | Value written to carry (0 = exclusive success) |

## Verification
The reservation cannot be read at the ports. A wrong value in it only shows up at the next exclusive store, as a wrong flag_val and mem_req pair one cycle after that store. The sequences therefore always follow each event that can change the reservation with an exclusive store. These events are a load, a store, an interrupt, an exception and a same-cycle collision. A plain store between a load and its store shows that a pass-through does not disturb the record.

// File: rtl/excl_monitor.sv
module excl_monitor #(
  parameter int AW = 32,
  parameter int SW = 2,
  parameter int ALIGN = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_store,
  input  logic          req_reg_form,
  input  logic          req_excl,
  input  logic          req_rev,
  input  logic [SW-1:0] req_size,
  input  logic [AW-1:0] req_addr,
  input  logic          irq_entry,
  input  logic          exc_entry,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [(1<<SW)-1:0] mem_bytes,
  output logic          mem_rev,
  output logic          flag_we,
  output logic          flag_val
);
  localparam int BW = 1 << SW;
  localparam logic [AW-1:0] EMPTY = '1;

  logic [AW-1:0] resv;
  logic          ex;
  logic [AW-1:0] addr_al;
  logic          fail;

  assign ex      = req_valid & req_reg_form & req_excl;
  assign addr_al = ex ? {req_addr[AW-1:ALIGN], {ALIGN{1'b0}}} : req_addr;
  assign fail    = ex & req_store & (addr_al != resv);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    resv <= EMPTY;
    else if (irq_entry | exc_entry) resv <= EMPTY;
    else if (ex & req_store)       resv <= EMPTY;
    else if (ex)                   resv <= addr_al;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_req   <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_bytes <= '0;
      mem_rev   <= 1'b0;
      flag_we   <= 1'b0;
      flag_val  <= 1'b0;
    end else begin
      mem_req   <= req_valid & ~fail;
      mem_we    <= req_valid & req_store;
      mem_addr  <= req_valid ? addr_al : '0;
      mem_bytes <= req_valid ? BW'(1) << req_size : '0;
      mem_rev   <= req_valid & req_reg_form & req_rev;
      flag_we   <= ex;
      flag_val  <= fail;
    end
  end
endmodule

module excl_monitor_chk #(
  parameter int AW = 32,
  parameter int BW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_store,
  input logic          req_reg_form,
  input logic          req_excl,
  input logic          irq_entry,
  input logic          exc_entry,
  input logic          mem_req,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic [BW-1:0] mem_bytes,
  input logic          flag_we,
  input logic          flag_val,
  input logic [AW-1:0] resv
);
  // R1
  always @(posedge clk)
    if (!rst_n) reset_idle_chk: assert (!mem_req && !flag_we && mem_bytes == '0);

  // R2
  imm_form_plain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_reg_form) |=> !flag_we);

  // R4
  excl_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flag_we |-> mem_addr[1:0] == 2'b00);

  // R6
  excl_success_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_we && !flag_val && mem_we) |-> mem_req);

  // R7
  excl_fail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_we && flag_val) |-> (!mem_req && mem_we));

  // R8
  store_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_store && req_reg_form && req_excl) |=> (&resv));

  // R9
  event_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_entry || exc_entry) |=> (&resv));

  // R10
  plain_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_store && !(req_reg_form && req_excl)) |=> (mem_req && mem_we && !flag_we));
endmodule

bind excl_monitor excl_monitor_chk #(.AW(AW), .BW(1 << SW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_store(req_store),
  .req_reg_form(req_reg_form), .req_excl(req_excl), .irq_entry(irq_entry),
  .exc_entry(exc_entry), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
  .mem_bytes(mem_bytes), .flag_we(flag_we), .flag_val(flag_val), .resv(resv)
);

// File: tb/excl_monitor_bench.sv
module excl_monitor_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 0, req_store = 0, req_reg_form = 0, req_excl = 0, req_rev = 0;
  logic [1:0] req_size = '0;
  logic [31:0] req_addr = '0;
  logic irq_entry = 0, exc_entry = 0;
  logic mem_req, mem_we, mem_rev, flag_we, flag_val;
  logic [31:0] mem_addr;
  logic [3:0] mem_bytes;

  always #5 clk = ~clk;

  excl_monitor u_excl_monitor (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_store(req_store),
    .req_reg_form(req_reg_form), .req_excl(req_excl), .req_rev(req_rev),
    .req_size(req_size), .req_addr(req_addr), .irq_entry(irq_entry),
    .exc_entry(exc_entry), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_bytes(mem_bytes), .mem_rev(mem_rev), .flag_we(flag_we), .flag_val(flag_val)
  );

  typedef struct {
    logic [40:0] v;
    string tag;
  } exp_t;

  exp_t sb[$];
  int checks = 0;
  int errors = 0;
  logic [31:0] m_resv = 32'hFFFF_FFFF;
  bit done = 0;

  function automatic logic [40:0] pack_out();
    return {mem_req, mem_we, mem_addr, mem_bytes, mem_rev, flag_we, flag_val};
  endfunction

  task automatic drive(input bit v, input bit st, input bit rf, input bit xb, input bit rb,
                       input logic [1:0] sz, input logic [31:0] a, input bit irq, input bit exc,
                       input string tag);
    exp_t e;
    bit ex, fail;
    logic [31:0] al;
    @(negedge clk);
    req_valid = v; req_store = st; req_reg_form = rf; req_excl = xb; req_rev = rb;
    req_size = sz; req_addr = a; irq_entry = irq; exc_entry = exc;
    ex = v && rf && xb;
    al = ex ? {a[31:2], 2'b00} : a;
    fail = ex && st && (al != m_resv);
    if (v) e.v = {!fail, st, al, 4'(4'd1 << sz), rf && rb, ex, fail};
    else   e.v = '0;
    e.tag = tag;
    sb.push_back(e);
    if (irq || exc)     m_resv = 32'hFFFF_FFFF;
    else if (ex && st)  m_resv = 32'hFFFF_FFFF;
    else if (ex)        m_resv = al;
  endtask

  task automatic idle(input bit irq, input bit exc, input string tag);
    drive(0, 0, 0, 0, 0, 2'd0, 32'h0, irq, exc, tag);
  endtask

  // R11: each item is compared one edge after it was driven
  always @(posedge clk) begin
    #2;
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      checks++;
      if (pack_out() !== e.v) begin
        errors++;
        $display("FAIL %s: actual %h expected %h", e.tag, pack_out(), e.v);
      end
    end
  end

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (pack_out() !== '0) begin
      errors++;
      $display("FAIL R1: actual %h expected %h", pack_out(), 41'h0);
    end
    rst_n = 1'b1;
    drive(1, 1, 1, 1, 0, 2'd2, 32'h0000_0000, 0, 0, "R1 store after reset fails");
    drive(1, 0, 0, 0, 0, 2'd0, 32'h0000_1003, 0, 0, "R3 R4 plain byte load unaligned");
    drive(1, 0, 1, 1, 0, 2'd2, 32'h0000_2002, 0, 0, "R5 R4 excl load");
    drive(1, 1, 1, 1, 0, 2'd2, 32'h0000_2001, 0, 0, "R6 excl store match");
    drive(1, 1, 1, 1, 0, 2'd2, 32'h0000_2000, 0, 0, "R8 store after success fails");
    drive(1, 0, 1, 1, 0, 2'd2, 32'h0000_3000, 0, 0, "R5 excl load");
    drive(1, 1, 1, 1, 0, 2'd2, 32'h0000_3004, 0, 0, "R7 excl store mismatch");
    drive(1, 1, 1, 1, 0, 2'd2, 32'h0000_3000, 0, 0, "R8 store after failure fails");
    drive(1, 0, 0, 1, 1, 2'd2, 32'h0000_4002, 0, 0, "R2 R3 imm form excl bit ignored");
    drive(1, 1, 0, 1, 0, 2'd1, 32'h0000_4001, 0, 0, "R2 R10 imm store with excl bit");
    drive(1, 1, 1, 1, 0, 2'd2, 32'h0000_4000, 0, 0, "R2 no reservation from imm load");
    drive(1, 0, 1, 1, 1, 2'd2, 32'h0000_5000, 0, 0, "R3 R5 rev excl load");
    drive(1, 1, 1, 0, 1, 2'd3, 32'h0000_5000, 0, 0, "R10 R3 plain rev store");
    drive(1, 1, 1, 1, 0, 2'd2, 32'h0000_5003, 0, 0, "R10 R6 plain store keeps reservation");
    idle(0, 0, "R11 idle");
    drive(1, 0, 1, 1, 0, 2'd2, 32'h0000_6000, 0, 0, "R5 load before irq");
    idle(1, 0, "R9 irq");
    drive(1, 1, 1, 1, 0, 2'd2, 32'h0000_6000, 0, 0, "R9 store after irq fails");
    drive(1, 0, 1, 1, 0, 2'd2, 32'h0000_7000, 0, 0, "R5 load before exc");
    idle(0, 1, "R9 exc");
    drive(1, 1, 1, 1, 0, 2'd2, 32'h0000_7000, 0, 0, "R9 store after exc fails");
    drive(1, 0, 1, 1, 0, 2'd2, 32'h0000_8000, 1, 0, "R9 load with irq same cycle");
    drive(1, 1, 1, 1, 0, 2'd2, 32'h0000_8000, 0, 0, "R9 irq beats load");
    drive(1, 0, 1, 1, 0, 2'd2, 32'h0000_9000, 0, 0, "R5 load");
    drive(1, 0, 1, 1, 0, 2'd2, 32'h0000_A000, 0, 0, "R5 load replaces reservation");
    drive(1, 1, 1, 1, 0, 2'd2, 32'h0000_9000, 0, 0, "R7 old address fails");
    drive(1, 0, 1, 1, 0, 2'd0, 32'h0000_B003, 0, 0, "R3 R4 excl byte code");
    drive(1, 1, 1, 1, 0, 2'd0, 32'h0000_B002, 0, 0, "R6 R4 aligned compare");
    drive(1, 1, 1, 1, 0, 2'd2, 32'hFFFF_FFFF, 0, 0, "R4 R7 all-ones address never matches");
    idle(0, 0, "R11 idle tail");
    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule